// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Master

This block turns a single internal request (32-bit address, 32-bit write word, read/write flag, start strobe) into one transfer on a narrow external bus where address and data share the same pins. The external device sees a chip-select, an address-latch strobe, a read/write direction line, an output enable and a clock derived from the core clock by a programmable integer ratio. The bus runs either 16 bits wide (two address beats followed by two data beats) or 8 bits wide (four address beats followed by four data beats).

Each beat lasts exactly one period of the divided clock, and beats change only where a divided-clock period begins. On a read the master releases the shared pins during the data beats, samples them at the end of each beat and assembles the returned word. Completion is marked by a one-cycle done pulse that carries the read word. Only single transfers are handled.

Top module: `muxbus_master`

## Requirements
- R1: After reset, sel_n is 1, addr_lat is 0, bus_drv is 0, rd_en_n is 1 and rsp_done is 0.
- R2: With cfg_wide=1 (latched at request), a transfer puts two address beats then two data beats on bus_out[15:0], upper half of each 32-bit word first.
- R3: With cfg_wide=0, a transfer puts four address beats then four data beats on bus_out[7:0], most significant byte first, with bus_out[15:8] held at 0.
- R4: addr_lat is 1 in every address beat and 0 in every data beat.
- R5: Every beat lasts exactly N core cycles, N being the effective divide ratio; dev_clk is 1 for the first (N+1)/2 cycles of each beat and 0 for the rest, so beats begin on dev_clk rising edges.
- R6: cfg_div below 2 acts as 2 and above 16 acts as 16; values in between are used as given. cfg_div is only changed while no transfer is active.
- R7: On a read (req_write=0), dir_rd is 1 for the whole transfer; in data beats bus_drv is 0 and rd_en_n is 0; bus_in is sampled in the last core cycle of each data beat and assembled first beat into the most significant position, using only bus_in[7:0] in 8-bit mode. On a write dir_rd is 0 and rd_en_n stays 1.
- R8: sel_n is 0 from the first address beat through the last data beat, and returns to 1 for at least N core cycles between transfers; a request made in the first cycle after completion starts its transfer exactly N cycles later.
- R9: rsp_done is a one-cycle pulse in the first cycle after the last data beat, and rsp_rdata holds the assembled read word in that cycle.
- R10: A req_valid pulse during the address or data beats of a transfer is ignored: that transfer continues unchanged and no further transfer follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start strobe for one transfer |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 32 | Transfer address |
| req_wdata | input | 32 | Write word |
| cfg_wide | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus; latched with the request |
| cfg_div | input | 5 | Divide ratio for the device clock, clamped to 2..16 |
| bus_in | input | 16 | Shared pins as seen from the device side |
| bus_out | output | 16 | Value driven onto the shared pins |
| bus_drv | output | 1 | Tristate enable for bus_out |
| sel_n | output | 1 | Chip-select, active low |
| addr_lat | output | 1 | Address-latch strobe, active high |
| dir_rd | output | 1 | Direction, 1 during a read transfer |
| rd_en_n | output | 1 | Output enable to the device, active low in read data beats |
| dev_clk | output | 1 | Divided device clock |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Assembled read word, valid with rsp_done |

## Verification
Two events can meet on one core clock edge: the completion of a transfer (done pulse, chip-select release) and the arrival of the next start strobe, since a request is accepted during the idle gap that follows. The bench issues a new request in the very cycle rsp_done is high and judges that the gap between transfers is exactly one divided period and that the second transfer carries its own address and data beat for beat. It also fires a start strobe in the middle of the address phase, where acceptance and beat progress would collide, and confirms the running transfer is untouched and nothing follows it.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    parameter int WORD_W   = 32;
    parameter int BUS_W    = 16;
    parameter int NARROW_W = 8;
    parameter int DIV_W    = 5;
    parameter int DIV_MIN  = 2;
    parameter int DIV_MAX  = 16;

    localparam int MAX_BEATS = WORD_W / NARROW_W;
    localparam int BEAT_W    = $clog2(MAX_BEATS);

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2,
        PH_GAP  = 2'd3
    } phase_e;

    typedef struct packed {
        logic              wr;
        logic              wide;
        logic [WORD_W-1:0] addr;
        logic [WORD_W-1:0] wdata;
    } req_t;

    function automatic logic [DIV_W-1:0] clamp_div(input logic [DIV_W-1:0] raw);
        if (int'(raw) < DIV_MIN)      return DIV_W'(DIV_MIN);
        else if (int'(raw) > DIV_MAX) return DIV_W'(DIV_MAX);
        else                          return raw;
    endfunction

    function automatic logic [BEAT_W-1:0] last_beat(input logic wide);
        if (wide) return BEAT_W'(WORD_W / BUS_W - 1);
        else      return BEAT_W'(WORD_W / NARROW_W - 1);
    endfunction

endpackage

// File: rtl/muxbus_clkdiv.sv
module muxbus_clkdiv
    import muxbus_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] cfg_div,
    output logic             tick,
    output logic             dev_clk
);

    logic [DIV_W-1:0] ratio;
    logic [DIV_W-1:0] half;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] cnt_nx;

    always_comb begin
        ratio  = clamp_div(cfg_div);
        half   = (ratio + DIV_W'(1)) >> 1;
        tick   = (cnt >= ratio - DIV_W'(1));
        cnt_nx = tick ? '0 : cnt + DIV_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            dev_clk <= 1'b0;
        end else begin
            cnt     <= cnt_nx;
            dev_clk <= (cnt_nx < half);
        end
    end

    // R6: with a steady ratio the phase counter never leaves its range
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (rst)
        $stable(ratio) |-> (cnt < ratio));

endmodule

// File: rtl/muxbus_seq.sv
module muxbus_seq
    import muxbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              start,
    input  req_t              req_in,
    output req_t              req_q,
    output phase_e            phase,
    output logic [BEAT_W-1:0] beat,
    output logic              done
);

    logic pend;
    logic accept;
    logic at_last;

    always_comb begin
        accept  = start && !pend && (phase == PH_IDLE || phase == PH_GAP);
        at_last = (beat == last_beat(req_q.wide));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            beat  <= '0;
            pend  <= 1'b0;
            done  <= 1'b0;
            req_q <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                pend  <= 1'b1;
                req_q <= req_in;
            end
            if (tick) begin
                unique case (phase)
                    PH_IDLE: begin
                        if (pend) begin
                            phase <= PH_ADDR;
                            beat  <= '0;
                            pend  <= 1'b0;
                        end
                    end
                    PH_ADDR: begin
                        if (at_last) begin
                            phase <= PH_DATA;
                            beat  <= '0;
                        end else begin
                            beat <= beat + BEAT_W'(1);
                        end
                    end
                    PH_DATA: begin
                        if (at_last) begin
                            phase <= PH_GAP;
                            beat  <= '0;
                            done  <= 1'b1;
                        end else begin
                            beat <= beat + BEAT_W'(1);
                        end
                    end
                    PH_GAP: begin
                        if (pend) begin
                            phase <= PH_ADDR;
                            beat  <= '0;
                            pend  <= 1'b0;
                        end else begin
                            phase <= PH_IDLE;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    // R10: a strobe arriving mid-transfer leaves the latched request alone
    p_busy_ignored_r10: assert property (@(posedge clk) disable iff (rst)
        (start && (phase == PH_ADDR || phase == PH_DATA)) |=> $stable(req_q));

    // R8: a transfer never begins without passing through a divided-clock boundary
    p_start_on_tick_r8: assert property (@(posedge clk) disable iff (rst)
        ($changed(phase) && phase == PH_ADDR) |-> $past(tick));

endmodule

// File: rtl/muxbus_lanes.sv
module muxbus_lanes
    import muxbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  phase_e            phase,
    input  logic [BEAT_W-1:0] beat,
    input  req_t              req,
    input  logic [BUS_W-1:0]  bus_in,
    output logic [BUS_W-1:0]  bus_out,
    output logic              bus_drv,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] word;
    logic [WORD_W-1:0] shifted;
    logic [BUS_W-1:0]  lane_mask;
    int                lane_w;
    int                sh;

    always_comb begin
        lane_w    = req.wide ? BUS_W : NARROW_W;
        sh        = WORD_W - lane_w * (int'(beat) + 1);
        word      = (phase == PH_ADDR) ? req.addr : req.wdata;
        shifted   = word >> sh;
        lane_mask = {BUS_W{1'b1}} >> (BUS_W - lane_w);
        bus_drv   = (phase == PH_ADDR) || (phase == PH_DATA && req.wr);
        bus_out   = bus_drv ? (shifted[BUS_W-1:0] & lane_mask) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (tick && phase == PH_DATA && !req.wr) begin
            if (req.wide)
                rdata <= {rdata[WORD_W-BUS_W-1:0], bus_in};
            else
                rdata <= {rdata[WORD_W-NARROW_W-1:0], bus_in[NARROW_W-1:0]};
        end
    end

    // R7: the read word only moves while a read data beat is closing
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(tick && phase == PH_DATA && !req.wr) |-> $stable(rdata));

endmodule

// File: rtl/muxbus_master.sv
module muxbus_master
    import muxbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [31:0]       req_addr,
    input  logic [31:0]       req_wdata,
    input  logic              cfg_wide,
    input  logic [4:0]        cfg_div,
    input  logic [15:0]       bus_in,
    output logic [15:0]       bus_out,
    output logic              bus_drv,
    output logic              sel_n,
    output logic              addr_lat,
    output logic              dir_rd,
    output logic              rd_en_n,
    output logic              dev_clk,
    output logic              rsp_done,
    output logic [31:0]       rsp_rdata
);

    logic              tick;
    req_t              req_in;
    req_t              req_q;
    phase_e            phase;
    logic [BEAT_W-1:0] beat;

    always_comb begin
        req_in.wr    = req_write;
        req_in.wide  = cfg_wide;
        req_in.addr  = req_addr;
        req_in.wdata = req_wdata;
    end

    muxbus_clkdiv i_div (
        .clk     (clk),
        .rst     (rst),
        .cfg_div (cfg_div),
        .tick    (tick),
        .dev_clk (dev_clk)
    );

    muxbus_seq i_seq (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .start  (req_valid),
        .req_in (req_in),
        .req_q  (req_q),
        .phase  (phase),
        .beat   (beat),
        .done   (rsp_done)
    );

    muxbus_lanes i_lanes (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .phase   (phase),
        .beat    (beat),
        .req     (req_q),
        .bus_in  (bus_in),
        .bus_out (bus_out),
        .bus_drv (bus_drv),
        .rdata   (rsp_rdata)
    );

    always_comb begin
        sel_n    = !(phase == PH_ADDR || phase == PH_DATA);
        addr_lat = (phase == PH_ADDR);
        dir_rd   = !sel_n && !req_q.wr;
        rd_en_n  = !(phase == PH_DATA && !req_q.wr);
    end

    // R4: the latch strobe only appears inside an active chip-select
    p_ale_in_sel_r4: assert property (@(posedge clk) disable iff (rst)
        addr_lat |-> !sel_n);

    // R7: the device is never enabled to drive while the master drives
    p_no_contention_r7: assert property (@(posedge clk) disable iff (rst)
        !rd_en_n |-> (!bus_drv && dir_rd));

    // R9: completion is a single-cycle pulse, seen with chip-select released
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);
    p_done_after_sel_r9: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> sel_n);

    // R5: select and strobe edges fall on divided-clock boundaries only
    p_edge_aligned_r5: assert property (@(posedge clk) disable iff (rst)
        (!$stable(sel_n) || !$stable(addr_lat)) |-> $past(tick));

endmodule

// File: tb/test_muxbus_master.sv
module test_muxbus_master;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        cfg_wide = 1'b1;
    logic [4:0]  cfg_div = 5'd2;
    logic [15:0] bus_in = '0;
    logic [15:0] bus_out;
    logic        bus_drv, sel_n, addr_lat, dir_rd, rd_en_n, dev_clk, rsp_done;
    logic [31:0] rsp_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    muxbus_master i_muxbus_master (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .cfg_wide(cfg_wide),
        .cfg_div(cfg_div), .bus_in(bus_in), .bus_out(bus_out), .bus_drv(bus_drv),
        .sel_n(sel_n), .addr_lat(addr_lat), .dir_rd(dir_rd), .rd_en_n(rd_en_n),
        .dev_clk(dev_clk), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int eff_div(input int raw);
        if (raw < 2) return 2;
        if (raw > 16) return 16;
        return raw;
    endfunction

    function automatic logic [15:0] exp_beat(input logic [31:0] w, input bit wide, input int k);
        if (wide) return w[31-16*k -: 16];
        return {8'h00, w[31-8*k -: 8]};
    endfunction

    task automatic start_req(input bit wr, input bit wide, input logic [31:0] a, input logic [31:0] d);
        req_write = wr;
        cfg_wide  = wide;
        req_addr  = a;
        req_wdata = d;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Follows one transfer cycle by cycle; returns at the first cycle with sel_n high again.
    task automatic watch(input bit wr, input bit wide, input int n, input logic [31:0] a,
                         input logic [31:0] d, input logic [31:0] rw, input bit poke,
                         input int hi0, output int hi);
        int nb;
        int c;
        string wtag;
        nb = wide ? 2 : 4;
        wtag = wide ? "R2" : "R3";
        hi = hi0;
        while (sel_n && hi < 100) begin
            @(negedge clk);
            hi++;
        end
        c = 0;
        while (!sel_n && c < 400) begin
            int bt;
            bit in_addr;
            int k;
            bt = c / n;
            in_addr = (bt < nb);
            k = in_addr ? bt : bt - nb;
            chk(dev_clk == ((c % n) < (n + 1) / 2), "R5 dev_clk phase", 32'(dev_clk), 32'((c % n) < (n + 1) / 2));
            chk(addr_lat == in_addr, "R4 addr_lat", 32'(addr_lat), 32'(in_addr));
            chk(dir_rd == !wr, "R7 dir_rd", 32'(dir_rd), 32'(!wr));
            chk(rsp_done == 1'b0, "R9 done early", 32'(rsp_done), 32'd0);
            if (in_addr || wr) begin
                logic [15:0] e;
                e = exp_beat(in_addr ? a : d, wide, k);
                chk(bus_drv == 1'b1, "R7 bus_drv on", 32'(bus_drv), 32'd1);
                chk(bus_out == e, wtag, 32'(bus_out), 32'(e));
                chk(rd_en_n == 1'b1, "R7 rd_en_n idle", 32'(rd_en_n), 32'd1);
            end else begin
                chk(bus_drv == 1'b0, "R7 bus released", 32'(bus_drv), 32'd0);
                chk(rd_en_n == 1'b0, "R7 rd_en_n", 32'(rd_en_n), 32'd0);
            end
            if (!wr && !in_addr)
                bus_in = exp_beat(rw, wide, k) | (wide ? 16'h0 : 16'($urandom_range(255, 1)) << 8);
            else
                bus_in = 16'($urandom());
            if (poke && c == n) begin
                req_valid = 1'b1;
                req_write = ~wr;
                req_addr  = ~a;
                req_wdata = ~d;
                cfg_wide  = ~wide;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            c++;
        end
        req_valid = 1'b0;
        cfg_wide = wide;
        chk(c == 2 * nb * n, "R8 sel_n low length", 32'(c), 32'(2 * nb * n));
        chk(rsp_done == 1'b1, "R9 done pulse", 32'(rsp_done), 32'd1);
        if (!wr) chk(rsp_rdata == rw, "R7 read word", rsp_rdata, rw);
    endtask

    task automatic one_xfer(input bit wr, input bit wide, input int raw_div, input bit poke);
        logic [31:0] a, d, rw;
        int n, hi;
        a = $urandom(); d = $urandom(); rw = $urandom();
        cfg_div = 5'(raw_div);
        n = eff_div(raw_div);
        start_req(wr, wide, a, d);
        watch(wr, wide, n, a, d, rw, poke, 0, hi);
        @(negedge clk);
        chk(rsp_done == 1'b0, "R9 single cycle", 32'(rsp_done), 32'd0);
        if (poke) begin
            bit stayed;
            stayed = 1'b1;
            repeat (3 * n + 2) begin
                if (!sel_n) stayed = 1'b0;
                @(negedge clk);
            end
            chk(stayed, "R10 no extra transfer", 32'(stayed), 32'd1);
        end else begin
            repeat (n) @(negedge clk);
        end
    endtask

    initial begin
        int seed;
        seed = $urandom(32'd61017);
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(sel_n == 1'b1, "R1 sel_n", 32'(sel_n), 32'd1);
        chk(addr_lat == 1'b0, "R1 addr_lat", 32'(addr_lat), 32'd0);
        chk(bus_drv == 1'b0, "R1 bus_drv", 32'(bus_drv), 32'd0);
        chk(rd_en_n == 1'b1, "R1 rd_en_n", 32'(rd_en_n), 32'd1);
        chk(rsp_done == 1'b0, "R1 rsp_done", 32'(rsp_done), 32'd0);

        // directed: both widths, both directions, R6 clamp corners
        one_xfer(1'b1, 1'b1, 2, 1'b0);
        one_xfer(1'b0, 1'b1, 3, 1'b0);
        one_xfer(1'b1, 1'b0, 4, 1'b0);
        one_xfer(1'b0, 1'b0, 5, 1'b0);
        one_xfer(1'b0, 1'b1, 0, 1'b0);   // R6 low clamp -> 2
        one_xfer(1'b1, 1'b0, 1, 1'b0);   // R6 low clamp -> 2
        one_xfer(1'b0, 1'b0, 31, 1'b0);  // R6 high clamp -> 16
        one_xfer(1'b1, 1'b1, 17, 1'b0);  // R6 high clamp -> 16
        one_xfer(1'b0, 1'b1, 16, 1'b0);

        // R10: strobe in the middle of the address phase
        one_xfer(1'b1, 1'b0, 3, 1'b1);
        one_xfer(1'b0, 1'b1, 6, 1'b1);

        // R8: request in the completion cycle, gap must be exactly N
        for (int i = 0; i < 4; i++) begin
            logic [31:0] a1, d1, r1, a2, d2, r2;
            int n, hi;
            bit w1, w2, wd;
            a1 = $urandom(); d1 = $urandom(); r1 = $urandom();
            a2 = $urandom(); d2 = $urandom(); r2 = $urandom();
            w1 = 1'($urandom()); w2 = 1'($urandom()); wd = 1'(i);
            cfg_div = 5'(2 + 3 * i);
            n = 2 + 3 * i;
            start_req(w1, wd, a1, d1);
            watch(w1, wd, n, a1, d1, r1, 1'b0, 0, hi);
            start_req(w2, !wd, a2, d2);
            watch(w2, !wd, n, a2, d2, r2, 1'b0, 1, hi);
            chk(hi == n, "R8 back-to-back gap", 32'(hi), 32'(n));
            @(negedge clk);
            repeat (n) @(negedge clk);
        end

        // random mix
        for (int i = 0; i < 30; i++) begin
            one_xfer(1'($urandom()), 1'($urandom()), int'($urandom_range(20, 0)), ($urandom_range(7, 0) == 0));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule